// File: doc/BRIEF.md
# Framing-Code Line Trigger

This block decides, for each video line, the moment at which a stream of sliced serial bits starts to be recorded as data bytes. At every horizontal sync it takes a new line setup: a 2-bit check selector and a wide-screen signalling flag. From these it fixes whether a framing check applies on this line and, if one does, which 8-bit framing pattern it uses.

After the data-start pulse, a checked line watches an 8-bit sliding window of the incoming bits. Recording begins on the first exact match with the chosen pattern, and byte boundaries start at the bit that follows the match. If no match appears within a bounded number of bits, the line is given up and a miss flag is raised. When checking is off, recording begins on the data-start pulse itself and no byte alignment is done. Recorded bits are packed into bytes, first bit in the most significant position, and each byte is marked by a one-cycle strobe.

Top module: `fct_line_trigger`

## Requirements
- R1: After reset, rec_en, aligned, miss and byte_valid are all 0.
- R2: The selector value present in the hsync cycle picks the check for the line: 00 = no check, 01 = pattern pat_a, 10 = pattern pat_b, 11 = pattern pat_c.
- R3: If wss_line is 1 in the hsync cycle, the line is checked against pat_wss whatever chk_sel holds.
- R4: With no check selected, rec_en rises in the cycle after start_det and aligned stays 0. The first valid bit after start_det is the first bit of the first byte.
- R5: On a checked line, the first valid bit that makes the last 8 bits (earliest bit in the MSB) equal the pattern sets rec_en and aligned in the next cycle. The first byte is built from the 8 valid bits that follow.
- R6: If no match occurs within 64 valid bits after start_det, miss rises and rec_en stays 0, and a later match is ignored until the next hsync. A match on the 64th bit still starts recording.
- R7: An hsync clears rec_en, aligned and miss in the following cycle and discards any partly built byte.
- R8: While recording, every 8 valid bits produce one byte_valid pulse one cycle long, with the first received bit in byte_out[7].
- R9: Bits that arrive before start_det produce no recording and no bytes. A start_det that arrives while hunting or recording has no effect.
- R10: A match needs 8 valid bits gathered since start_det. Fewer bits never match, even when pattern 8'h00 meets the cleared window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync | input | 1 | Horizontal sync pulse; loads the line setup and clears the line state |
| chk_sel | input | 2 | Per-line framing check select |
| wss_line | input | 1 | Line carries wide-screen signalling |
| pat_a | input | 8 | Framing pattern for selector 01 |
| pat_b | input | 8 | Framing pattern for selector 10 |
| pat_c | input | 8 | Framing pattern for selector 11 |
| pat_wss | input | 8 | Framing pattern for signalling lines |
| start_det | input | 1 | Data-start detect pulse |
| bit_valid | input | 1 | Strobe for bit_in |
| bit_in | input | 1 | Sliced serial bit |
| rec_en | output | 1 | Recording enabled on this line |
| aligned | output | 1 | Recording is byte-aligned to a framing match |
| miss | output | 1 | Framing code not found on this line |
| byte_out | output | 8 | Assembled byte |
| byte_valid | output | 1 | One-cycle strobe for byte_out |

## Verification
Every result is registered once. rec_en, aligned and miss change in the cycle after the start_det, hsync or bit_valid cycle that causes the change. byte_valid comes in the cycle after the eighth bit of a byte. The bench drives each stimulus for exactly one cycle from a falling edge and samples the flags at the next falling edge, the first point at which the registered result can be seen. Expected bytes go into a queue when a test sends them. A monitor pops one entry on each byte_valid falling-edge sample, so an early, late, extra or missing byte shows up as a mismatch or as an entry left in the queue.

// File: rtl/fct_pkg.sv
// Shared types for the framing-code line trigger.
package fct_pkg;

    // Per-line check selector encoding
    typedef enum logic [1:0] {
        CK_OFF = 2'b00,
        CK_A   = 2'b01,
        CK_B   = 2'b10,
        CK_C   = 2'b11
    } chk_sel_e;

    // Per-line trigger state
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_HUNT = 2'b01,
        ST_REC  = 2'b10,
        ST_MISS = 2'b11
    } line_st_e;

endpackage

// File: rtl/fct_line_cfg.sv
// Line setup latch: captures the check mode and the framing pattern in the
// hsync cycle. Assumes hsync is a single-cycle pulse per line; the pattern
// inputs are only sampled on hsync.
module fct_line_cfg #(
    parameter int PAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync,
    input  logic [1:0]       chk_sel,
    input  logic             wss_line,
    input  logic [PAT_W-1:0] pat_a,
    input  logic [PAT_W-1:0] pat_b,
    input  logic [PAT_W-1:0] pat_c,
    input  logic [PAT_W-1:0] pat_wss,
    output logic             chk_on,
    output logic [PAT_W-1:0] pat_q
);
    import fct_pkg::*;

    chk_sel_e         sel_e;
    logic             chk_on_nx;
    logic [PAT_W-1:0] pat_nx;

    assign sel_e = chk_sel_e'(chk_sel);

    // Choose the line's pattern; the signalling flag overrides the selector
    always_comb begin
        chk_on_nx = 1'b1;
        pat_nx    = pat_wss;
        if (!wss_line) begin
            unique case (sel_e)
                CK_OFF: begin
                    chk_on_nx = 1'b0;
                    pat_nx    = '0;
                end
                CK_A:    pat_nx = pat_a;
                CK_B:    pat_nx = pat_b;
                default: pat_nx = pat_c;
            endcase
        end
    end

    // Hold the line setup from one hsync to the next
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_on <= 1'b0;
            pat_q  <= '0;
        end else if (hsync) begin
            chk_on <= chk_on_nx;
            pat_q  <= pat_nx;
        end
    end

endmodule

// File: rtl/fct_hunt.sv
// Framing hunt: after start_det, either starts recording at once (no check)
// or slides a PAT_W-bit window over the valid bits until it equals the
// pattern. Gives up after HUNT_LIMIT bits. hsync wins over all other events.
module fct_hunt #(
    parameter int PAT_W      = 8,
    parameter int HUNT_LIMIT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync,
    input  logic             start_det,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic             chk_on,
    input  logic [PAT_W-1:0] pat_q,
    output logic             rec_en,
    output logic             aligned,
    output logic             miss
);
    import fct_pkg::*;

    localparam int CNT_W = (HUNT_LIMIT > 2) ? $clog2(HUNT_LIMIT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HUNT_LIMIT - 1);
    localparam logic [CNT_W-1:0] CNT_FILL = CNT_W'(PAT_W - 1);

    line_st_e         state;
    logic [PAT_W-1:0] win;
    logic [PAT_W-1:0] win_nx;
    logic [CNT_W-1:0] cnt;
    logic             aligned_q;
    logic             hit;

    // Window with the new bit appended and the match test on it
    always_comb begin
        win_nx = {win[PAT_W-2:0], bit_in};
        hit    = (cnt >= CNT_FILL) && (win_nx == pat_q);
    end

    // Line state machine, window and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            win       <= '0;
            cnt       <= '0;
            aligned_q <= 1'b0;
        end else if (hsync) begin
            state     <= ST_IDLE;
            win       <= '0;
            cnt       <= '0;
            aligned_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_det) begin
                        state <= chk_on ? ST_HUNT : ST_REC;
                        win   <= '0;
                        cnt   <= '0;
                    end
                end
                ST_HUNT: begin
                    if (bit_valid) begin
                        win <= win_nx;
                        cnt <= cnt + 1'b1;
                        if (hit) begin
                            state     <= ST_REC;
                            aligned_q <= 1'b1;
                        end else if (cnt == CNT_LAST) begin
                            state <= ST_MISS;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign rec_en  = (state == ST_REC);
    assign miss    = (state == ST_MISS);
    assign aligned = aligned_q;

endmodule

// File: rtl/fct_byte_asm.sv
// Byte assembler: packs valid bits into BYTE_W-bit words, first bit in the
// MSB, while recording is enabled. A partial word is dropped on hsync or
// when recording ends.
module fct_byte_asm #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              rec_en,
    input  logic              bit_valid,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_valid
);
    localparam int BC_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] sh_nx;
    logic [BC_W-1:0]   bcnt;

    // Shift value with the incoming bit
    assign sh_nx = {sh[BYTE_W-2:0], bit_in};

    // Shift register, bit counter and output strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh         <= '0;
            bcnt       <= '0;
            byte_out   <= '0;
            byte_valid <= 1'b0;
        end else if (hsync || !rec_en) begin
            bcnt       <= '0;
            byte_valid <= 1'b0;
        end else if (bit_valid) begin
            sh <= sh_nx;
            if (bcnt == BC_LAST) begin
                bcnt       <= '0;
                byte_out   <= sh_nx;
                byte_valid <= 1'b1;
            end else begin
                bcnt       <= bcnt + 1'b1;
                byte_valid <= 1'b0;
            end
        end else begin
            byte_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/fct_line_trigger.sv
// Top of the framing-code line trigger: line setup latch, framing hunt and
// byte assembler. Assumes hsync, start_det and bit_valid are synchronous
// single-cycle strobes.
module fct_line_trigger #(
    parameter int PAT_W      = 8,
    parameter int HUNT_LIMIT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync,
    input  logic [1:0]       chk_sel,
    input  logic             wss_line,
    input  logic [PAT_W-1:0] pat_a,
    input  logic [PAT_W-1:0] pat_b,
    input  logic [PAT_W-1:0] pat_c,
    input  logic [PAT_W-1:0] pat_wss,
    input  logic             start_det,
    input  logic             bit_valid,
    input  logic             bit_in,
    output logic             rec_en,
    output logic             aligned,
    output logic             miss,
    output logic [PAT_W-1:0] byte_out,
    output logic             byte_valid
);
    logic             chk_on;
    logic [PAT_W-1:0] pat_q;

    fct_line_cfg #(.PAT_W(PAT_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .hsync    (hsync),
        .chk_sel  (chk_sel),
        .wss_line (wss_line),
        .pat_a    (pat_a),
        .pat_b    (pat_b),
        .pat_c    (pat_c),
        .pat_wss  (pat_wss),
        .chk_on   (chk_on),
        .pat_q    (pat_q)
    );

    fct_hunt #(.PAT_W(PAT_W), .HUNT_LIMIT(HUNT_LIMIT)) u_hunt (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync     (hsync),
        .start_det (start_det),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .chk_on    (chk_on),
        .pat_q     (pat_q),
        .rec_en    (rec_en),
        .aligned   (aligned),
        .miss      (miss)
    );

    fct_byte_asm #(.BYTE_W(PAT_W)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hsync      (hsync),
        .rec_en     (rec_en),
        .bit_valid  (bit_valid),
        .bit_in     (bit_in),
        .byte_out   (byte_out),
        .byte_valid (byte_valid)
    );

endmodule

// File: rtl/fct_line_trigger_chk.sv
// Protocol checker for the framing-code line trigger, bound to the top.
module fct_line_trigger_chk (
    input logic clk,
    input logic rst_n,
    input logic hsync,
    input logic rec_en,
    input logic aligned,
    input logic miss,
    input logic byte_valid
);
    AST_ALIGN_NEEDS_REC: assert property (@(posedge clk) disable iff (!rst_n)
        aligned |-> rec_en); // R5
    AST_MISS_NO_REC: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> !rec_en); // R6
    AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && !hsync) |=> miss); // R6
    AST_HSYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |=> (!rec_en && !aligned && !miss && !byte_valid)); // R7
    AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid); // R8
    AST_BYTE_IN_REC: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> rec_en); // R8
endmodule

bind fct_line_trigger fct_line_trigger_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hsync      (hsync),
    .rec_en     (rec_en),
    .aligned    (aligned),
    .miss       (miss),
    .byte_valid (byte_valid)
);

// File: tb/fct_line_trigger_test.sv
// Scoreboard bench for the framing-code line trigger.
module fct_line_trigger_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync = 1'b0;
    logic [1:0] chk_sel = 2'b00;
    logic       wss_line = 1'b0;
    logic [7:0] pat_a = 8'hA5, pat_b = 8'h5A, pat_c = 8'h66, pat_wss = 8'h1E;
    logic       start_det = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic       rec_en, aligned, miss, byte_valid;
    logic [7:0] byte_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    fct_line_trigger uut (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .chk_sel(chk_sel),
        .wss_line(wss_line), .pat_a(pat_a), .pat_b(pat_b), .pat_c(pat_c),
        .pat_wss(pat_wss), .start_det(start_det), .bit_valid(bit_valid),
        .bit_in(bit_in), .rec_en(rec_en), .aligned(aligned), .miss(miss),
        .byte_out(byte_out), .byte_valid(byte_valid)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Flags packed as {rec_en, aligned, miss}
    task automatic chk_flags(input string req, input logic [2:0] exp);
        chk(req, {5'b0, rec_en, aligned, miss}, {5'b0, exp});
    endtask

    // Monitor: pop one expected byte per strobe
    always @(negedge clk) begin
        if (rst_n && byte_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R8 unexpected byte actual=%h expected=none", byte_out);
            end else begin
                chk("R8 byte", byte_out, exp_q.pop_front());
            end
        end
    end

    task automatic line(input logic [1:0] sel, input logic wss);
        @(negedge clk);
        hsync = 1'b1; chk_sel = sel; wss_line = wss;
        @(negedge clk);
        hsync = 1'b0; chk_sel = 2'b00; wss_line = 1'b0;
    endtask

    task automatic start();
        start_det = 1'b1;
        @(negedge clk);
        start_det = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        bit_valid = 1'b1; bit_in = b;
        @(negedge clk);
        bit_valid = 1'b0; bit_in = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    // Driver: queue the expected byte, then send it
    task automatic rec_byte(input logic [7:0] v);
        exp_q.push_back(v);
        send_byte(v);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_flags("R1 reset flags", 3'b000);
        chk("R1 byte_valid", {7'b0, byte_valid}, 8'h00);
        rst_n = 1'b1;

        // R9: bits before start_det do nothing
        line(2'b01, 1'b0);
        send_byte(8'hA5);
        chk_flags("R9 idle bits", 3'b000);

        // R2 / R5: pattern A with leading noise
        start();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        send_byte(8'hA5);
        chk_flags("R5 pattern A match", 3'b110);
        rec_byte(8'h3C);
        start();                                   // R9: ignored while recording
        rec_byte(8'hF0);
        chk_flags("R9 start_det during rec", 3'b110);

        // R7: hsync mid-byte clears
        send_bit(1'b1); send_bit(1'b0);
        line(2'b10, 1'b0);
        chk_flags("R7 hsync clears", 3'b000);

        // R2: selector 10 uses pattern B, pattern A does not trigger
        start();
        send_byte(8'hA5);
        chk_flags("R2 pattern A ignored on sel 10", 3'b000);
        send_byte(8'h5A);
        chk_flags("R2 pattern B match", 3'b110);
        rec_byte(8'h81);

        // R3: signalling line overrides selector 01
        line(2'b01, 1'b1);
        start();
        send_byte(8'hA5);
        chk_flags("R3 selector overridden", 3'b000);
        send_byte(8'h1E);
        chk_flags("R3 signalling pattern", 3'b110);
        rec_byte(8'h42);

        // R2: selector 11 uses pattern C
        line(2'b11, 1'b0);
        start();
        send_byte(8'h66);
        chk_flags("R2 pattern C match", 3'b110);
        rec_byte(8'h99);

        // R4: no check, record from start_det
        line(2'b00, 1'b0);
        start();
        chk_flags("R4 record on start", 3'b100);
        rec_byte(8'hC3);
        rec_byte(8'h0F);
        chk_flags("R4 not aligned", 3'b100);

        // R6: miss after 64 bits, later match ignored
        line(2'b01, 1'b0);
        start();
        for (int i = 0; i < 63; i++) send_bit(1'b0);
        chk_flags("R6 before limit", 3'b000);
        send_bit(1'b0);
        chk_flags("R6 miss raised", 3'b001);
        send_byte(8'hA5);
        chk_flags("R6 match after miss ignored", 3'b001);
        line(2'b01, 1'b0);
        chk_flags("R7 hsync clears miss", 3'b000);

        // R6: match on the 64th bit still records
        start();
        for (int i = 0; i < 56; i++) send_bit(1'b0);
        send_byte(8'hA5);
        chk_flags("R6 match on last bit", 3'b110);
        rec_byte(8'h5E);

        // R10: zero pattern needs 8 bits
        pat_a = 8'h00;
        line(2'b01, 1'b0);
        start();
        for (int i = 0; i < 7; i++) send_bit(1'b0);
        chk_flags("R10 seven bits no match", 3'b000);
        send_bit(1'b0);
        chk_flags("R10 eighth bit matches", 3'b110);
        rec_byte(8'hB7);

        repeat (3) @(negedge clk);
        chk("R8 queue drained", 8'(exp_q.size()), 8'h00);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule